// File: doc/BRIEF.md
# Dual-Clock Timer/Counter with Synchronized Host Access

This block is a small timer/counter whose counting logic runs in its own clock domain. That domain is clocked either by the system clock or by a free-running oscillator input that has no fixed relation to it. A divider with several taps slows the chosen source down, and the divided ticks advance an up-counter. A tick that finds the count equal to a compare value raises a compare event. A tick that carries the count from its top value back to zero raises an overflow event.

The host reaches the block through a flat register port in the system clock domain. Each write to the compare value or to the clock-select setting is carried into the timer domain by a toggle handshake with a held data word. While that transfer is in progress a busy bit is set, and further writes to that register are dropped. The count returned to the host is a shadow word. The timer domain keeps pushing this word across as fast as the handshake allows. Compare and overflow events are passed back as toggles and become sticky flags, which drive the interrupt outputs.

Top module: `dualclk_timer`

## Requirements
- R1: After reset every readable register returns 0, and `irq_cmp`, `irq_ovf` and `cmp_out` are low.
- R2: The clock-select field CTRL[2:0] (address 0) sets the counting rate. Code 0 holds the count. Code 1 counts every source edge. Codes 2 to 7 count once every 8, 32, 64, 128, 256 and 1024 source edges, in that order.
- R3: The source bit CFG[0] (address 4) selects the source clock. When it is 0 the source is `clk`; when it is 1 the source is `osc_clk`. The bit reads back at CFG[0].
- R4: Writing 1 to CFG[1] clears the 10-bit divider. The next divided tick then comes a full divide period after the clear. This bit reads as 0.
- R5: The count advances by exactly one per tick and wraps from 255 to 0. The wrap sets the overflow flag STATUS[1] (address 3).
- R6: A tick that occurs while the count equals the compare value (address 1) sets the compare flag STATUS[0] and toggles `cmp_out` in the timer domain.
- R7: Writing 1 to a flag bit in STATUS clears that flag, and writing 0 leaves it as it is. If a new event arrives in the same cycle as the clear, the flag stays set.
- R8: Address 2 returns a system-domain copy of the count. The timer domain refreshes this copy continually.
- R9: A write to the compare value sets STATUS[2], and a write to CTRL sets STATUS[3]. Each bit stays set until the new value has reached the timer domain. A write to a register whose busy bit is set is ignored, and the register reads back its earlier value.
- R10: A flag reaches the host at least 3 system cycles after the timer edge that raised it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; host port and flags |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | 1 | Alternative timer source clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_cmp | output | 1 | Compare flag |
| irq_ovf | output | 1 | Overflow flag |
| cmp_out | output | 1 | Compare output, toggled in the timer domain |

## Verification
The bench uses the default 8-bit counter and 3-bit address. With those defaults, a full wrap takes only 256 ticks at the undivided rate, and the slowest divider tap can be measured over 50 ticks in about 51,000 cycles. The oscillator input runs seven times slower than the system clock, so the source switch gives a clearly different count rate. Running the timer from the system clock makes the flag crossing latency an exact cycle count, which the bench measures against the toggle of `cmp_out`.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PRE_W  = 10;
  localparam int unsigned CS_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_CMP   = 3'd1,
    A_COUNT = 3'd2,
    A_STAT  = 3'd3,
    A_CFG   = 3'd4
  } reg_addr_e;

  // low-bit mask whose all-ones pattern marks a divided tick
  function automatic logic [PRE_W-1:0] tap_mask(input logic [CS_W-1:0] cs);
    case (cs)
      3'd2:    return 10'h007;
      3'd3:    return 10'h01F;
      3'd4:    return 10'h03F;
      3'd5:    return 10'h07F;
      3'd6:    return 10'h0FF;
      3'd7:    return 10'h3FF;
      default: return 10'h000;
    endcase
  endfunction

  function automatic logic tap_hit(input logic [CS_W-1:0] cs, input logic [PRE_W-1:0] pre);
    return (cs != '0) && ((pre & tap_mask(cs)) == tap_mask(cs));
  endfunction
endpackage

// File: rtl/dct_sync2.sv
module dct_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/dct_hs_xfer.sv
module dct_hs_xfer #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic [W-1:0] hold,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dout
);
  logic req, ack_s, req_s, req_seen, dst_upd;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req  <= 1'b0;
      hold <= RST_VAL;
    end else if (load && !busy) begin
      hold <= din;
      req  <= ~req;
    end
  end

  dct_sync2 u_ack_sync (.clk(src_clk), .rst_n(src_rst_n), .d(req_seen), .q(ack_s));
  assign busy = req ^ ack_s;

  dct_sync2 u_req_sync (.clk(dst_clk), .rst_n(dst_rst_n), .d(req), .q(req_s));
  assign dst_upd = req_s ^ req_seen;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_seen <= 1'b0;
      dout     <= RST_VAL;
    end else begin
      req_seen <= req_s;
      if (dst_upd) dout <= hold;
    end
  end
endmodule

// File: rtl/dct_evt_xfer.sv
module dct_evt_xfer (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic evt,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic pulse
);
  logic tog, tog_s, tog_prev;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)  tog <= 1'b0;
    else if (evt)    tog <= ~tog;
  end

  dct_sync2 u_sync (.clk(dst_clk), .rst_n(dst_rst_n), .d(tog), .q(tog_s));

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) tog_prev <= 1'b0;
    else            tog_prev <= tog_s;
  end

  assign pulse = tog_s ^ tog_prev;
endmodule

// File: rtl/dct_prescaler.sv
module dct_prescaler import dct_pkg::*; (
  input  logic            tclk,
  input  logic            trst_n,
  input  logic            clr,
  input  logic [CS_W-1:0] cs,
  output logic            tick
);
  logic [PRE_W-1:0] pre;

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n)  pre <= '0;
    else if (clr) pre <= '0;
    else          pre <= pre + 1'b1;
  end

  assign tick = tap_hit(cs, pre);
endmodule

// File: rtl/dct_core.sv
module dct_core #(
  parameter int CNT_W = 8
) (
  input  logic             tclk,
  input  logic             trst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             cmp_evt,
  output logic             cmp_out
);
  assign ovf_evt = tick && (cnt == '1);
  assign cmp_evt = tick && (cnt == cmp);

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      cnt     <= '0;
      cmp_out <= 1'b0;
    end else begin
      if (tick)    cnt     <= cnt + 1'b1;
      if (cmp_evt) cmp_out <= ~cmp_out;
    end
  end
endmodule

// File: rtl/dualclk_timer.sv
module dualclk_timer import dct_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq_cmp,
  output logic              irq_ovf,
  output logic              cmp_out
);
  localparam int DATA_W = CNT_W;

  logic src_sel, tclk, trst_n;
  logic [1:0] trst_sh;
  logic wr_ctrl, wr_cmp, wr_stat, wr_cfg;
  logic ctrl_busy, cmp_busy, cnt_busy;
  logic [CS_W-1:0]  ctrl_hold, cs_t;
  logic [CNT_W-1:0] cmp_hold, cmp_t, cnt_t, cnt_hold, cnt_shadow;
  logic psr_t, tick_t, ovf_evt_t, cmp_evt_t;
  logic ovf_pulse_sys, cmp_pulse_sys;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cmp  = wr_en && (addr == A_CMP);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_cfg  = wr_en && (addr == A_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_sel <= 1'b0;
    else if (wr_cfg) src_sel <= wdata[0];
  end

  assign tclk = src_sel ? osc_clk : clk;

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) trst_sh <= 2'b00;
    else        trst_sh <= {trst_sh[0], 1'b1};
  end
  assign trst_n = trst_sh[1];

  dct_hs_xfer #(.W(CS_W), .RST_VAL('0)) u_ctrl_x (
    .src_clk(clk), .src_rst_n(rst_n), .load(wr_ctrl), .din(wdata[CS_W-1:0]),
    .busy(ctrl_busy), .hold(ctrl_hold),
    .dst_clk(tclk), .dst_rst_n(trst_n), .dout(cs_t));

  dct_hs_xfer #(.W(CNT_W), .RST_VAL('0)) u_cmp_x (
    .src_clk(clk), .src_rst_n(rst_n), .load(wr_cmp), .din(wdata),
    .busy(cmp_busy), .hold(cmp_hold),
    .dst_clk(tclk), .dst_rst_n(trst_n), .dout(cmp_t));

  dct_hs_xfer #(.W(CNT_W), .RST_VAL('0)) u_cnt_x (
    .src_clk(tclk), .src_rst_n(trst_n), .load(1'b1), .din(cnt_t),
    .busy(cnt_busy), .hold(cnt_hold),
    .dst_clk(clk), .dst_rst_n(rst_n), .dout(cnt_shadow));

  dct_evt_xfer u_psr_x (
    .src_clk(clk), .src_rst_n(rst_n), .evt(wr_cfg && wdata[1]),
    .dst_clk(tclk), .dst_rst_n(trst_n), .pulse(psr_t));

  dct_prescaler u_pre (
    .tclk(tclk), .trst_n(trst_n), .clr(psr_t), .cs(cs_t), .tick(tick_t));

  dct_core #(.CNT_W(CNT_W)) u_core (
    .tclk(tclk), .trst_n(trst_n), .tick(tick_t), .cmp(cmp_t), .cnt(cnt_t),
    .ovf_evt(ovf_evt_t), .cmp_evt(cmp_evt_t), .cmp_out(cmp_out));

  dct_evt_xfer u_ovf_x (
    .src_clk(tclk), .src_rst_n(trst_n), .evt(ovf_evt_t),
    .dst_clk(clk), .dst_rst_n(rst_n), .pulse(ovf_pulse_sys));

  dct_evt_xfer u_cmpe_x (
    .src_clk(tclk), .src_rst_n(trst_n), .evt(cmp_evt_t),
    .dst_clk(clk), .dst_rst_n(rst_n), .pulse(cmp_pulse_sys));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_cmp <= 1'b0;
      irq_ovf <= 1'b0;
    end else begin
      if (cmp_pulse_sys)             irq_cmp <= 1'b1;
      else if (wr_stat && wdata[0])  irq_cmp <= 1'b0;
      if (ovf_pulse_sys)             irq_ovf <= 1'b1;
      else if (wr_stat && wdata[1])  irq_ovf <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[CS_W-1:0] = ctrl_hold;
      A_CMP:   rdata = cmp_hold;
      A_COUNT: rdata = cnt_shadow;
      A_STAT:  rdata[3:0] = {ctrl_busy, cmp_busy, irq_ovf, irq_cmp};
      A_CFG:   rdata[0] = src_sel;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dualclk_timer_chk.sv
module dualclk_timer_chk import dct_pkg::*; #(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tclk,
  input logic              trst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic              cmp_busy,
  input logic              ctrl_busy,
  input logic [CNT_W-1:0]  cmp_hold,
  input logic [CS_W-1:0]   ctrl_hold,
  input logic [CS_W-1:0]   cs_t,
  input logic [CNT_W-1:0]  cnt_t,
  input logic              cnt_busy,
  input logic [CNT_W-1:0]  cnt_hold,
  input logic              ovf_pulse_sys,
  input logic              irq_ovf,
  input logic              cmp_pulse_sys,
  input logic              irq_cmp
);
  AST_CMP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMP && cmp_busy) |=> $stable(cmp_hold)); // R9
  AST_CTRL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL && ctrl_busy) |=> $stable(ctrl_hold)); // R9
  AST_CMP_BUSY_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMP && !cmp_busy) |=> cmp_busy); // R9
  AST_COUNT_STEP: assert property (@(posedge tclk) disable iff (!trst_n)
    (cnt_t != $past(cnt_t)) |-> (cnt_t == $past(cnt_t) + 1'b1)); // R5
  AST_STOPPED_HOLDS: assert property (@(posedge tclk) disable iff (!trst_n)
    (cs_t == '0) |=> $stable(cnt_t)); // R2
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && wdata[1] && !ovf_pulse_sys) |=> !irq_ovf); // R7
  AST_CMP_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse_sys |=> irq_cmp); // R6
  AST_SHADOW_SOURCE_HELD: assert property (@(posedge tclk) disable iff (!trst_n)
    cnt_busy |=> $stable(cnt_hold)); // R8
endmodule

bind dualclk_timer dualclk_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tclk(tclk), .trst_n(trst_n),
  .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cmp_busy(cmp_busy), .ctrl_busy(ctrl_busy), .cmp_hold(cmp_hold), .ctrl_hold(ctrl_hold),
  .cs_t(cs_t), .cnt_t(cnt_t), .cnt_busy(cnt_busy), .cnt_hold(cnt_hold),
  .ovf_pulse_sys(ovf_pulse_sys), .irq_ovf(irq_ovf),
  .cmp_pulse_sys(cmp_pulse_sys), .irq_cmp(irq_cmp));

// File: tb/tb_dualclk_timer.sv
`timescale 1ns/1ps
module tb_dualclk_timer;
  logic clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq_cmp, irq_ovf, cmp_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5  clk = ~clk;
  always #35 osc_clk = ~osc_clk;

  dualclk_timer dut (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf), .cmp_out(cmp_out));

  // rate table: select code, window in system cycles, expected count advance
  localparam int NV = 7;
  localparam int VEC_CS  [NV] = '{1, 2, 3, 4, 5, 6, 7};
  localparam int VEC_CYC [NV] = '{200, 800, 3200, 6400, 12800, 25600, 51200};
  localparam int VEC_EXP [NV] = '{200, 100, 100, 100, 100, 100, 50};

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    int k;
    k = 0;
    rd(3'd3, s);
    while (s[3:2] != 2'b00 && k < 300) begin
      cyc(1); rd(3'd3, s); k++;
    end
    chk(tag, s[3:2] == 2'b00, s[3:2], 0);
  endtask

  function automatic int cnt_delta(input logic [7:0] a, input logic [7:0] b);
    return int'(8'(b - a));
  endfunction

  initial begin
    #1_600_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, c0, c1, c2;
    bit p0;
    int lat, k;

    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reg reset", v == 8'd0, v, 0);
    end
    chk("R1 outputs reset", {irq_cmp, irq_ovf, cmp_out} == 3'b000, {irq_cmp, irq_ovf, cmp_out}, 0);

    // R2: rate per select code, system clock source
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 8'(VEC_CS[i]));
      wait_idle("R9 ctrl transfer");
      cyc(10);
      rd(3'd2, c0);
      cyc(VEC_CYC[i]);
      rd(3'd2, c1);
      k = cnt_delta(c0, c1);
      chk($sformatf("R2 rate code %0d", VEC_CS[i]),
          (k >= VEC_EXP[i] - 2) && (k <= VEC_EXP[i] + 2), k, VEC_EXP[i]);
    end

    // R2: code 0 holds the count
    wr(3'd0, 8'd0);
    wait_idle("R9 ctrl transfer");
    cyc(10);
    rd(3'd2, c0);
    cyc(300);
    rd(3'd2, c1);
    chk("R2 stopped count", c0 == c1, c1, c0);

    // R5 / R7: overflow flag and write-one-to-clear
    wr(3'd3, 8'h03);
    rd(3'd3, v);
    chk("R7 flags cleared", v[1:0] == 2'b00, v[1:0], 0);
    wr(3'd0, 8'd1);
    k = 0;
    while (!irq_ovf && k < 700) begin cyc(1); k++; end
    chk("R5 overflow flag", irq_ovf == 1'b1, irq_ovf, 1);
    rd(3'd3, v);
    chk("R5 status ovf bit", v[1] == 1'b1, v[1], 1);
    cyc(20);
    rd(3'd2, v);
    chk("R5 wrapped count", v >= 8'd8 && v <= 8'd40, v, 24);
    wr(3'd3, 8'h00);
    chk("R7 zero write keeps flag", irq_ovf == 1'b1, irq_ovf, 1);
    wr(3'd3, 8'h02);
    chk("R7 one write clears flag", irq_ovf == 1'b0, irq_ovf, 0);

    // R6 / R10: compare event, output toggle and crossing latency
    wr(3'd0, 8'd0);
    wait_idle("R9 ctrl transfer");
    cyc(5);
    wr(3'd3, 8'h03);
    wr(3'd1, 8'd100);
    wait_idle("R9 cmp transfer");
    rd(3'd1, v);
    chk("R6 compare readback", v == 8'd100, v, 100);
    p0 = cmp_out;
    wr(3'd0, 8'd1);
    k = 0;
    while (cmp_out == p0 && k < 600) begin cyc(1); k++; end
    chk("R6 cmp_out toggled", cmp_out != p0, cmp_out, !p0);
    chk("R10 flag not early", irq_cmp == 1'b0, irq_cmp, 0);
    lat = 0;
    while (!irq_cmp && lat < 20) begin cyc(1); lat++; end
    chk("R10 flag latency", lat >= 3 && lat <= 4, lat, 3);
    rd(3'd3, v);
    chk("R6 status cmp bit", v[0] == 1'b1, v[0], 1);
    cyc(20);
    rd(3'd2, v);
    chk("R8 count past compare", v > 8'd100 && v < 8'd140, v, 120);

    // R9: writes while busy are dropped
    wr(3'd0, 8'd0);
    wait_idle("R9 ctrl transfer");
    wr(3'd1, 8'd50);
    rd(3'd3, v);
    chk("R9 cmp busy set", v[2] == 1'b1, v[2], 1);
    wr(3'd1, 8'd60);
    wait_idle("R9 cmp transfer");
    rd(3'd1, v);
    chk("R9 cmp busy write ignored", v == 8'd50, v, 50);
    wr(3'd0, 8'd1);
    rd(3'd3, v);
    chk("R9 ctrl busy set", v[3] == 1'b1, v[3], 1);
    wr(3'd0, 8'd0);
    wait_idle("R9 ctrl transfer");
    rd(3'd0, v);
    chk("R9 ctrl busy write ignored", v == 8'd1, v, 1);

    // R4: prescaler clear postpones the divided tick
    wr(3'd0, 8'd7);
    wait_idle("R9 ctrl transfer");
    wr(3'd4, 8'h02);
    cyc(20);
    rd(3'd2, c0);
    cyc(900);
    wr(3'd4, 8'h02);
    cyc(900);
    rd(3'd2, c1);
    chk("R4 no tick after clear", c1 == c0, c1, c0);
    cyc(300);
    rd(3'd2, c2);
    chk("R4 tick after full period", c2 == 8'(c0 + 1), c2, 8'(c0 + 1));
    rd(3'd4, v);
    chk("R4 clear bit reads zero", v[1] == 1'b0, v[1], 0);

    // R3: oscillator source, seven times slower
    wr(3'd0, 8'd0);
    wait_idle("R9 ctrl transfer");
    wr(3'd4, 8'h01);
    rd(3'd4, v);
    chk("R3 source bit", v[0] == 1'b1, v[0], 1);
    wr(3'd0, 8'd1);
    wait_idle("R9 ctrl transfer osc");
    cyc(30);
    rd(3'd2, c0);
    cyc(700);
    rd(3'd2, c1);
    k = cnt_delta(c0, c1);
    chk("R3 osc rate", k >= 97 && k <= 103, k, 100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule